// File: doc/BRIEF.md
# Mode Command Descriptor Control

This block holds one control and status word for each mode code of a serial-bus remote terminal. It updates that word when the protocol engine reports the end of a mode command. Each word has two bits the host may write: a make-busy request and a broadcast-interrupt enable. It also has three status flags kept by the block: the ping-pong buffer select, a descriptor-accessed flag and a broadcast-received flag.

The protocol engine uses two strobes. At the start of a command it issues a lookup strobe with the mode code number. One cycle later it gets back the data buffer to use, whether to answer with Busy, and whether received mode data must be held off from storage. At the end of a command it issues a single-cycle completion strobe with error, illegal, broadcast and T/R qualifiers. The block uses these to decide whether the buffer select flips, which flags set, and whether a message interrupt and a log entry are raised.

The host reads and writes descriptor words through a simple strobed register port. A read clears the accessed flag of the word it reads. Three global configuration inputs shape the behaviour: ping-pong versus indexed buffering, broadcast disable, and interrupt enable. There is also a master reset and a software reset.

Top module: `mcd_ctrl_top`

## Requirements
Descriptor word layout used throughout: bit 0 make-busy (host RW), bit 1 broadcast-interrupt enable (host RW), bit 2 buffer select (1 = buffer B), bit 3 accessed, bit 4 broadcast received.
- R1: After master reset every descriptor word reads 0, irq_out is 0 and log_valid is 0.
- R2: With cfg_pingpong = 1, the buffer-select bit (bit 2) of the completed code inverts after each completion with evt_err = 0, evt_illegal = 0 and make-busy = 0. A later lookup of that code reports the new bit on lkp_buf_b.
- R3: The buffer-select bit is unchanged after a completion with evt_err = 1, with evt_illegal = 1, or for a code whose make-busy bit is 1.
- R4: With cfg_pingpong = 0 (indexed mode), completions leave the buffer-select bit unchanged and lookups report lkp_buf_b = 0.
- R5: Every accepted completion sets the accessed bit (bit 3) of its code. A host read returns the word as it was before the read and then clears that word's accessed bit. If a completion for the same code arrives in the same cycle as the read, the bit stays set.
- R6: A lookup of a code whose make-busy bit is 1 returns lkp_busy = 1. It also returns lkp_inhibit = 1 when the code is 16 or above, and lkp_inhibit = 0 when the code is below 16.
- R7: The broadcast-received bit (bit 4) sets on a completion with evt_bcast = 1, evt_tr = 0 and no error or illegal flag. A broadcast completion with evt_tr = 1 does not set it.
- R8: With cfg_bcast_dis = 1, a completion with evt_bcast = 1 is ignored: no bit of the descriptor word changes and no interrupt is raised.
- R9: A completion that would set the broadcast-received bit, for a code whose bit 1 is 1 while cfg_irq_en = 1, gives three results in the next cycle: log_valid pulses for one cycle, log_code carries the code, and irq_out rises. irq_out then holds until irq_ack. With cfg_irq_en = 0, no interrupt is raised.
- R10: Software reset clears bits 2, 3 and 4 of every word and clears irq_out. It leaves bits 0 and 1 as they were.
- R11: A host write updates only bits 0 and 1 of the addressed word. The values written to bits 2 to 4 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Master reset, synchronous, active high |
| soft_rst | input | 1 | Software reset of status flags and pending interrupt |
| cfg_pingpong | input | 1 | 1 = ping-pong buffering, 0 = indexed single buffer |
| cfg_bcast_dis | input | 1 | 1 = broadcast commands are not recognized |
| cfg_irq_en | input | 1 | Global enable for broadcast-received interrupts |
| cmd_stb | input | 1 | Lookup request at command start |
| cmd_code | input | 5 | Mode code number for the lookup |
| lkp_valid | output | 1 | Lookup result valid, one cycle after cmd_stb |
| lkp_buf_b | output | 1 | 1 = use data pointer B, 0 = pointer A |
| lkp_busy | output | 1 | Answer with Busy status |
| lkp_inhibit | output | 1 | Do not store received mode data words |
| evt_stb | input | 1 | Single-cycle message completion strobe |
| evt_code | input | 5 | Mode code number of the completed message |
| evt_err | input | 1 | Message ended in error |
| evt_illegal | input | 1 | Command was illegal |
| evt_bcast | input | 1 | Command was broadcast |
| evt_tr | input | 1 | T/R bit of the command (1 = transmit) |
| host_rd | input | 1 | Host read strobe |
| host_wr | input | 1 | Host write strobe |
| host_addr | input | 5 | Descriptor index for the host access |
| host_wdata | input | 5 | Host write data |
| host_rdata | output | 5 | Read data, valid one cycle after host_rd |
| irq_out | output | 1 | Message interrupt, held until acknowledged |
| irq_ack | input | 1 | Host interrupt acknowledge |
| log_valid | output | 1 | One-cycle interrupt log write strobe |
| log_code | output | 5 | Mode code number for the log entry |

## Verification
The assertions assume the completion strobe lasts one cycle and that its qualifiers are stable while it is high. They also assume irq_ack is not asserted while log_valid is high. The directed stimulus drives every strobe for exactly one clock, between falling edges. It asserts irq_ack only after checking that the log pulse has ended. The one deliberate overlap is a host read and a completion for the same code in the same cycle, which tests the priority that R5 gives.

// File: rtl/mcd_pkg.sv
package mcd_pkg;

  localparam int DESC_W = 5;

  // Descriptor word, packed so that busy is bit 0 and bcr is bit 4
  typedef struct packed {
    logic bcr;
    logic acc;
    logic bsel;
    logic birq;
    logic busy;
  } desc_t;

  // Actions decoded from one completion strobe
  typedef struct packed {
    logic upd;
    logic set_acc;
    logic toggle;
    logic set_bcr;
    logic irq;
  } evt_act_t;

endpackage

// File: rtl/mcd_evt_dec.sv
module mcd_evt_dec
  import mcd_pkg::*;
(
  input  logic     evt_stb,
  input  logic     evt_err,
  input  logic     evt_illegal,
  input  logic     evt_bcast,
  input  logic     evt_tr,
  input  logic     cfg_bcast_dis,
  input  logic     cfg_pingpong,
  input  logic     cfg_irq_en,
  input  logic     code_busy,
  input  logic     code_birq,
  output evt_act_t act
);

  logic accepted;
  logic clean;
  logic bcast_rx;

  always_comb begin
    // A broadcast while broadcasts are disabled was never a valid command
    accepted = evt_stb && !(evt_bcast && cfg_bcast_dis);
    clean    = accepted && !evt_err && !evt_illegal;
    bcast_rx = clean && evt_bcast && !evt_tr;

    act.upd     = accepted;
    act.set_acc = accepted;
    act.toggle  = clean && cfg_pingpong && !code_busy;
    act.set_bcr = bcast_rx;
    act.irq     = bcast_rx && code_birq && cfg_irq_en;
  end

endmodule

// File: rtl/mcd_desc_bank.sv
module mcd_desc_bank
  import mcd_pkg::*;
#(
  parameter int NUM_CODES = 32,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 soft_rst,
  input  logic                 host_rd,
  input  logic                 host_wr,
  input  logic [CODE_W-1:0]    host_addr,
  input  logic [DESC_W-1:0]    host_wdata,
  output logic [DESC_W-1:0]    host_rdata,
  input  evt_act_t             act,
  input  logic [CODE_W-1:0]    evt_code,
  output logic [NUM_CODES-1:0] busy_v,
  output logic [NUM_CODES-1:0] birq_v,
  output logic [NUM_CODES-1:0] bsel_v,
  output logic [NUM_CODES-1:0] acc_v,
  output logic [NUM_CODES-1:0] bcr_v
);

  desc_t wr_word;
  assign wr_word = desc_t'(host_wdata);

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_entry
    logic hit_wr, hit_rd, hit_evt;
    assign hit_wr  = host_wr && (host_addr == CODE_W'(g));
    assign hit_rd  = host_rd && (host_addr == CODE_W'(g));
    assign hit_evt = act.upd && (evt_code == CODE_W'(g));

    // Host-writable control bits: master reset only
    always_ff @(posedge clk) begin
      if (rst) begin
        busy_v[g] <= 1'b0;
        birq_v[g] <= 1'b0;
      end else if (hit_wr) begin
        busy_v[g] <= wr_word.busy;
        birq_v[g] <= wr_word.birq;
      end
    end

    // Status flags: master or software reset
    always_ff @(posedge clk) begin
      if (rst || soft_rst) begin
        bsel_v[g] <= 1'b0;
        acc_v[g]  <= 1'b0;
        bcr_v[g]  <= 1'b0;
      end else begin
        if (hit_evt && act.toggle)
          bsel_v[g] <= ~bsel_v[g];
        if (hit_evt && act.set_acc)
          acc_v[g] <= 1'b1;
        else if (hit_rd)
          acc_v[g] <= 1'b0;
        if (hit_evt && act.set_bcr)
          bcr_v[g] <= 1'b1;
      end
    end
  end

  desc_t rd_word;
  always_comb begin
    rd_word.busy = busy_v[host_addr];
    rd_word.birq = birq_v[host_addr];
    rd_word.bsel = bsel_v[host_addr];
    rd_word.acc  = acc_v[host_addr];
    rd_word.bcr  = bcr_v[host_addr];
  end

  always_ff @(posedge clk) begin
    if (rst)
      host_rdata <= '0;
    else if (host_rd)
      host_rdata <= rd_word;
  end

endmodule

// File: rtl/mcd_irq_ctrl.sv
module mcd_irq_ctrl #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              fire,
  input  logic [CODE_W-1:0] fire_code,
  input  logic              irq_ack,
  output logic              irq_out,
  output logic              log_valid,
  output logic [CODE_W-1:0] log_code
);

  always_ff @(posedge clk) begin
    if (rst || soft_rst)
      irq_out <= 1'b0;
    else if (fire)
      irq_out <= 1'b1;
    else if (irq_ack)
      irq_out <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      log_valid <= 1'b0;
      log_code  <= '0;
    end else begin
      log_valid <= fire && !soft_rst;
      if (fire)
        log_code <= fire_code;
    end
  end

endmodule

// File: rtl/mcd_lookup.sv
module mcd_lookup #(
  parameter int NUM_CODES = 32,
  parameter int DATA_LO   = 16,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_stb,
  input  logic [CODE_W-1:0]    cmd_code,
  input  logic                 cfg_pingpong,
  input  logic [NUM_CODES-1:0] bsel_v,
  input  logic [NUM_CODES-1:0] busy_v,
  output logic                 lkp_valid,
  output logic                 lkp_buf_b,
  output logic                 lkp_busy,
  output logic                 lkp_inhibit
);

  logic busy_sel, data_code;
  assign busy_sel  = busy_v[cmd_code];
  assign data_code = (cmd_code >= CODE_W'(DATA_LO));

  always_ff @(posedge clk) begin
    if (rst) begin
      lkp_valid   <= 1'b0;
      lkp_buf_b   <= 1'b0;
      lkp_busy    <= 1'b0;
      lkp_inhibit <= 1'b0;
    end else begin
      lkp_valid <= cmd_stb;
      if (cmd_stb) begin
        lkp_buf_b   <= cfg_pingpong && bsel_v[cmd_code];
        lkp_busy    <= busy_sel;
        lkp_inhibit <= busy_sel && data_code;
      end
    end
  end

endmodule

// File: rtl/mcd_ctrl_top.sv
module mcd_ctrl_top
  import mcd_pkg::*;
#(
  parameter int NUM_CODES = 32,
  parameter int DATA_LO   = 16,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              soft_rst,
  input  logic              cfg_pingpong,
  input  logic              cfg_bcast_dis,
  input  logic              cfg_irq_en,
  input  logic              cmd_stb,
  input  logic [CODE_W-1:0] cmd_code,
  output logic              lkp_valid,
  output logic              lkp_buf_b,
  output logic              lkp_busy,
  output logic              lkp_inhibit,
  input  logic              evt_stb,
  input  logic [CODE_W-1:0] evt_code,
  input  logic              evt_err,
  input  logic              evt_illegal,
  input  logic              evt_bcast,
  input  logic              evt_tr,
  input  logic              host_rd,
  input  logic              host_wr,
  input  logic [CODE_W-1:0] host_addr,
  input  logic [DESC_W-1:0] host_wdata,
  output logic [DESC_W-1:0] host_rdata,
  output logic              irq_out,
  input  logic              irq_ack,
  output logic              log_valid,
  output logic [CODE_W-1:0] log_code
);

  logic [NUM_CODES-1:0] busy_v, birq_v, bsel_v, acc_v, bcr_v;
  evt_act_t act;

  mcd_evt_dec u_dec (
    .evt_stb      (evt_stb),
    .evt_err      (evt_err),
    .evt_illegal  (evt_illegal),
    .evt_bcast    (evt_bcast),
    .evt_tr       (evt_tr),
    .cfg_bcast_dis(cfg_bcast_dis),
    .cfg_pingpong (cfg_pingpong),
    .cfg_irq_en   (cfg_irq_en),
    .code_busy    (busy_v[evt_code]),
    .code_birq    (birq_v[evt_code]),
    .act          (act)
  );

  mcd_desc_bank #(.NUM_CODES(NUM_CODES)) u_bank (
    .clk       (clk),
    .rst       (rst),
    .soft_rst  (soft_rst),
    .host_rd   (host_rd),
    .host_wr   (host_wr),
    .host_addr (host_addr),
    .host_wdata(host_wdata),
    .host_rdata(host_rdata),
    .act       (act),
    .evt_code  (evt_code),
    .busy_v    (busy_v),
    .birq_v    (birq_v),
    .bsel_v    (bsel_v),
    .acc_v     (acc_v),
    .bcr_v     (bcr_v)
  );

  mcd_irq_ctrl #(.CODE_W(CODE_W)) u_irq (
    .clk      (clk),
    .rst      (rst),
    .soft_rst (soft_rst),
    .fire     (act.irq),
    .fire_code(evt_code),
    .irq_ack  (irq_ack),
    .irq_out  (irq_out),
    .log_valid(log_valid),
    .log_code (log_code)
  );

  mcd_lookup #(.NUM_CODES(NUM_CODES), .DATA_LO(DATA_LO)) u_lkp (
    .clk         (clk),
    .rst         (rst),
    .cmd_stb     (cmd_stb),
    .cmd_code    (cmd_code),
    .cfg_pingpong(cfg_pingpong),
    .bsel_v      (bsel_v),
    .busy_v      (busy_v),
    .lkp_valid   (lkp_valid),
    .lkp_buf_b   (lkp_buf_b),
    .lkp_busy    (lkp_busy),
    .lkp_inhibit (lkp_inhibit)
  );

endmodule

// File: rtl/mcd_ctrl_chk.sv
module mcd_ctrl_chk #(
  parameter int NUM_CODES = 32,
  localparam int CODE_W = $clog2(NUM_CODES)
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 soft_rst,
  input logic                 cfg_bcast_dis,
  input logic                 evt_stb,
  input logic [CODE_W-1:0]    evt_code,
  input logic                 evt_err,
  input logic                 evt_illegal,
  input logic                 evt_bcast,
  input logic                 host_wr,
  input logic                 host_rd,
  input logic                 irq_out,
  input logic                 irq_ack,
  input logic                 log_valid,
  input logic                 lkp_busy,
  input logic                 lkp_inhibit,
  input logic [NUM_CODES-1:0] busy_v,
  input logic [NUM_CODES-1:0] bsel_v,
  input logic [NUM_CODES-1:0] acc_v,
  input logic [NUM_CODES-1:0] bcr_v
);

  // R3: no buffer flip after error, illegal or busy completions
  assert_no_flip_on_bad_R3: assert property (@(posedge clk) disable iff (rst)
    (evt_stb && (evt_err || evt_illegal || busy_v[evt_code]) && !soft_rst)
      |=> (bsel_v == $past(bsel_v)));

  // R2: without a completion the buffer selects hold
  assert_bsel_idle_R2: assert property (@(posedge clk) disable iff (rst)
    (!evt_stb && !soft_rst) |=> $stable(bsel_v));

  // R10: software reset clears every status flag
  assert_soft_clear_R10: assert property (@(posedge clk) disable iff (rst)
    soft_rst |=> (bsel_v == '0 && acc_v == '0 && bcr_v == '0 && !irq_out));

  // R8: disabled broadcasts leave status and log untouched
  assert_bcast_dis_R8: assert property (@(posedge clk) disable iff (rst)
    (evt_stb && evt_bcast && cfg_bcast_dis && !soft_rst)
      |=> ($stable(bsel_v) && $stable(bcr_v) && !log_valid));

  // R9: interrupt holds until acknowledged
  assert_irq_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (irq_out && !irq_ack && !soft_rst) |=> irq_out);

  // R9: a log entry always comes with the interrupt output
  assert_log_with_irq_R9: assert property (@(posedge clk) disable iff (rst)
    log_valid |-> irq_out);

  // R6: store inhibit only for busy codes
  assert_inhibit_busy_R6: assert property (@(posedge clk) disable iff (rst)
    lkp_inhibit |-> lkp_busy);

  // R11: host writes alone do not touch status flags
  assert_wr_no_status_R11: assert property (@(posedge clk) disable iff (rst)
    (host_wr && !evt_stb && !host_rd && !soft_rst)
      |=> ($stable(bsel_v) && $stable(bcr_v) && $stable(acc_v)));

endmodule

bind mcd_ctrl_top mcd_ctrl_chk #(.NUM_CODES(NUM_CODES)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .soft_rst     (soft_rst),
  .cfg_bcast_dis(cfg_bcast_dis),
  .evt_stb      (evt_stb),
  .evt_code     (evt_code),
  .evt_err      (evt_err),
  .evt_illegal  (evt_illegal),
  .evt_bcast    (evt_bcast),
  .host_wr      (host_wr),
  .host_rd      (host_rd),
  .irq_out      (irq_out),
  .irq_ack      (irq_ack),
  .log_valid    (log_valid),
  .lkp_busy     (lkp_busy),
  .lkp_inhibit  (lkp_inhibit),
  .busy_v       (busy_v),
  .bsel_v       (bsel_v),
  .acc_v        (acc_v),
  .bcr_v        (bcr_v)
);

// File: tb/sim_mcd_ctrl_top.sv
`timescale 1ns/1ps
module sim_mcd_ctrl_top;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, soft_rst, cfg_pingpong, cfg_bcast_dis, cfg_irq_en;
  logic cmd_stb; logic [4:0] cmd_code;
  logic lkp_valid, lkp_buf_b, lkp_busy, lkp_inhibit;
  logic evt_stb; logic [4:0] evt_code;
  logic evt_err, evt_illegal, evt_bcast, evt_tr;
  logic host_rd, host_wr; logic [4:0] host_addr, host_wdata, host_rdata;
  logic irq_out, irq_ack, log_valid; logic [4:0] log_code;

  int total = 0;
  int bad = 0;
  bit done = 0;

  mcd_ctrl_top u0 (.*);

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send_evt(int code, bit err, bit ill, bit bc, bit tr, bit rd = 0);
    @(negedge clk);
    evt_stb = 1; evt_code = 5'(code); evt_err = err; evt_illegal = ill;
    evt_bcast = bc; evt_tr = tr;
    host_rd = rd; host_addr = 5'(code);
    @(negedge clk);
    evt_stb = 0; evt_err = 0; evt_illegal = 0; evt_bcast = 0; evt_tr = 0;
    host_rd = 0;
  endtask

  task automatic read_word(int code, output int w);
    @(negedge clk);
    host_rd = 1; host_addr = 5'(code);
    @(negedge clk);
    host_rd = 0;
    w = int'(host_rdata);
  endtask

  task automatic write_word(int code, int val);
    @(negedge clk);
    host_wr = 1; host_addr = 5'(code); host_wdata = 5'(val);
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic lookup(int code);
    @(negedge clk);
    cmd_stb = 1; cmd_code = 5'(code);
    @(negedge clk);
    cmd_stb = 0;
  endtask

  task automatic pulse_soft();
    @(negedge clk); soft_rst = 1;
    @(negedge clk); soft_rst = 0;
  endtask

  task automatic t_reset();
    int w;
    for (int i = 0; i < 32; i += 7) begin
      read_word(i, w);
      chk("R1 word after reset", w, 0);
    end
    chk("R1 irq_out after reset", int'(irq_out), 0);
    chk("R1 log_valid after reset", int'(log_valid), 0);
  endtask

  task automatic t_pingpong();
    int w;
    send_evt(3, 0, 0, 0, 0);
    read_word(3, w);
    chk("R2 bsel+acc after good msg", w, 12);
    lookup(3);
    chk("R2 lkp_valid", int'(lkp_valid), 1);
    chk("R2 lkp_buf_b is B", int'(lkp_buf_b), 1);
    send_evt(3, 0, 0, 0, 1);
    read_word(3, w);
    chk("R2 bsel back to A", w & 4, 0);
  endtask

  task automatic t_no_toggle();
    int w;
    send_evt(3, 1, 0, 0, 0);
    read_word(3, w);
    chk("R3 no flip after error", w & 4, 0);
    send_evt(3, 0, 1, 0, 0);
    read_word(3, w);
    chk("R3 no flip after illegal", w & 4, 0);
    write_word(3, 1);
    send_evt(3, 0, 0, 0, 0);
    read_word(3, w);
    chk("R3 no flip when busy", w, 9);
  endtask

  task automatic t_busy();
    lookup(3);
    chk("R6 busy low code", int'(lkp_busy), 1);
    chk("R6 inhibit low code", int'(lkp_inhibit), 0);
    write_word(20, 1);
    lookup(20);
    chk("R6 busy code 20", int'(lkp_busy), 1);
    chk("R6 inhibit code 20", int'(lkp_inhibit), 1);
    lookup(21);
    chk("R6 not busy code 21", int'(lkp_busy), 0);
    chk("R6 no inhibit code 21", int'(lkp_inhibit), 0);
  endtask

  task automatic t_indexed();
    int w;
    cfg_pingpong = 0;
    send_evt(5, 0, 0, 0, 0);
    read_word(5, w);
    chk("R4 indexed no flip", w & 4, 0);
    cfg_pingpong = 1;
    send_evt(5, 0, 0, 0, 0);
    cfg_pingpong = 0;
    lookup(5);
    chk("R4 indexed lookup reports A", int'(lkp_buf_b), 0);
    cfg_pingpong = 1;
  endtask

  task automatic t_accessed();
    int w;
    send_evt(11, 1, 0, 0, 0);
    read_word(11, w);
    chk("R5 acc set on error msg", w, 8);
    read_word(11, w);
    chk("R5 acc cleared by read", w, 0);
    send_evt(11, 1, 0, 0, 0, 1);
    chk("R5 read returns pre-clear word", int'(host_rdata), 0);
    read_word(11, w);
    chk("R5 set wins over read-clear", w, 8);
  endtask

  task automatic t_bcast();
    int w;
    send_evt(1, 0, 0, 1, 0);
    read_word(1, w);
    chk("R7 bcr set", w & 16, 16);
    send_evt(2, 0, 0, 1, 1);
    read_word(2, w);
    chk("R7 no bcr with T/R=1", w & 16, 0);
    cfg_bcast_dis = 1;
    write_word(6, 2);
    send_evt(6, 0, 0, 1, 0);
    chk("R8 no log when disabled", int'(log_valid), 0);
    read_word(6, w);
    chk("R8 word untouched", w, 2);
    cfg_bcast_dis = 0;
  endtask

  task automatic t_irq();
    write_word(7, 2);
    send_evt(7, 0, 0, 1, 0);
    chk("R9 log_valid pulse", int'(log_valid), 1);
    chk("R9 log_code", int'(log_code), 7);
    chk("R9 irq_out raised", int'(irq_out), 1);
    repeat (3) @(negedge clk);
    chk("R9 log pulse ended", int'(log_valid), 0);
    chk("R9 irq_out held", int'(irq_out), 1);
    irq_ack = 1; @(negedge clk); irq_ack = 0;
    chk("R9 irq_out cleared by ack", int'(irq_out), 0);
    cfg_irq_en = 0;
    send_evt(7, 0, 0, 1, 0);
    chk("R9 no log when irq disabled", int'(log_valid), 0);
    chk("R9 no irq when disabled", int'(irq_out), 0);
    cfg_irq_en = 1;
  endtask

  task automatic t_soft();
    int w;
    write_word(8, 1);
    send_evt(9, 0, 0, 1, 0);
    write_word(12, 2);
    send_evt(12, 0, 0, 1, 0);
    pulse_soft();
    chk("R10 irq cleared", int'(irq_out), 0);
    read_word(9, w);
    chk("R10 status cleared", w, 0);
    read_word(8, w);
    chk("R10 busy kept", w, 1);
    read_word(12, w);
    chk("R10 birq kept", w, 2);
  endtask

  task automatic t_write();
    int w;
    write_word(10, 31);
    read_word(10, w);
    chk("R11 status bits ignored", w, 3);
    write_word(10, 0);
    read_word(10, w);
    chk("R11 control bits cleared", w, 0);
  endtask

  initial begin
    rst = 1; soft_rst = 0; cfg_pingpong = 1; cfg_bcast_dis = 0; cfg_irq_en = 1;
    cmd_stb = 0; cmd_code = 0; evt_stb = 0; evt_code = 0; evt_err = 0;
    evt_illegal = 0; evt_bcast = 0; evt_tr = 0; host_rd = 0; host_wr = 0;
    host_addr = 0; host_wdata = 0; irq_ack = 0;
    repeat (4) @(negedge clk);
    rst = 0;
    t_reset();
    t_pingpong();
    t_no_toggle();
    t_busy();
    t_indexed();
    t_accessed();
    t_bcast();
    t_irq();
    t_soft();
    t_write();
    if (!done) begin
      done = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
    end
    $finish;
  end

endmodule